// File: doc/BRIEF.md
# Peripheral Service Request Arbiter

This block chooses which pending service request a communications coprocessor handles next. Requests can come from several places: a reset source, a DMA bus-error source, a host command source, a bank of DMA-emulation channels, and the receive and transmit sides of the fast, multichannel and serial channels. A further group of double-buffered serial controllers raises plain requests only.

The fast, multichannel and serial channels can each flag a pending request as urgent. Every urgent request competes in one shared urgent tier. That tier sits below the three system sources and ranks its members in the same order that normal traffic uses. A mode input places the DMA-emulation group either above the urgent tier (mode 0) or between the urgent tier and normal traffic (mode 1).

The decision is registered. It is presented as a one-hot grant, an encoded grant index and a valid flag. It stays frozen until the consumer acknowledges it with `accept`.

Top module: `svc_req_arbiter`

## Requirements
- R1: While `rst_n` is low, `grant_valid` is 0, `grant` is all zeros and `grant_idx` is 0, and this takes effect immediately.
- R2: `reset_req` wins over every other request and is granted as index 0.
- R3: When `reset_req` is low, `bus_err_req` wins over all remaining requests and is granted as index 1.
- R4: When neither of those is set, `host_cmd_req` wins and is granted as index 2.
- R5: With `dma_low_opt` = 0, a DMA-emulation request beats every urgent and normal request. DMA channel k is granted as index 3+k, and the lowest k wins.
- R6: With `dma_low_opt` = 1, any urgent request beats the DMA-emulation group, and the DMA group still beats every non-urgent channel request.
- R7: An urgent request is a channel request whose urgent flag is also set. Urgent requests beat non-urgent channel requests. Among themselves they follow the R8 order. An urgent flag raised without the matching request has no effect.
- R8: Channel requests are granted lowest index first. The indices are:
  - 7 for fast 0 rx and 8 for fast 0 tx;
  - 9 and 10 for multichannel 0 rx and 1 rx;
  - 11 and 12 for multichannel 0 tx and 1 tx;
  - 13 and 14 for fast 1 rx and tx, then 15 and 16 for fast 2 rx and tx;
  - 17+2k for serial k rx and 18+2k for serial k tx;
  - 25+k for double-buffered controller k.
- R9: While `grant_valid` is 1 and `accept` is 0, `grant`, `grant_idx` and `grant_valid` hold, whatever the inputs do, including `dma_low_opt`. A new decision is registered at the clock edge where `accept` is 1 or `grant_valid` is 0, and it uses the inputs and mode present at that edge.
- R10: When nothing is requested at a decision edge, `grant_valid` goes to 0 with `grant` all zeros. When `grant_valid` is 1, `grant` has exactly one bit set, at position `grant_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reset_req | input | 1 | Reset service request |
| bus_err_req | input | 1 | DMA bus error request |
| host_cmd_req | input | 1 | Host command request |
| dma_req | input | N_DMA (4) | DMA-emulation channel requests |
| dma_low_opt | input | 1 | 0: DMA above urgent tier; 1: below it |
| fast_rx_req | input | N_FAST (3) | Fast channel receive requests |
| fast_tx_req | input | N_FAST (3) | Fast channel transmit requests |
| fast_rx_urg | input | N_FAST (3) | Urgent flags, fast receive |
| fast_tx_urg | input | N_FAST (3) | Urgent flags, fast transmit |
| multi_rx_req | input | N_MULTI (2) | Multichannel receive requests |
| multi_tx_req | input | N_MULTI (2) | Multichannel transmit requests |
| multi_rx_urg | input | N_MULTI (2) | Urgent flags, multichannel receive |
| multi_tx_urg | input | N_MULTI (2) | Urgent flags, multichannel transmit |
| ser_rx_req | input | N_SER (4) | Serial channel receive requests |
| ser_tx_req | input | N_SER (4) | Serial channel transmit requests |
| ser_rx_urg | input | N_SER (4) | Urgent flags, serial receive |
| ser_tx_urg | input | N_SER (4) | Urgent flags, serial transmit |
| dbuf_req | input | N_DBUF (4) | Double-buffered controller requests |
| accept | input | 1 | Consumer takes the current grant |
| grant | output | TOTAL (29) | One-hot grant |
| grant_idx | output | clog2(TOTAL) (5) | Encoded grant index |
| grant_valid | output | 1 | A grant is outstanding |

## Verification
The case that needs the most care is a mode change and a new high-ranked request arriving in the same cycle while a grant is still held. The bench builds this case directly. It holds a fast-channel grant with `accept` low, then flips `dma_low_opt` and raises a DMA request together with an urgent request. It then checks that the held grant does not move over several cycles. Next it pulses `accept` once and checks that the new decision follows the new mode: the urgent request wins. A second collision puts an urgent request in a higher tier than a normal request from a source that ranks earlier in the R8 order, and the bench checks that the tier decides the winner.

// File: rtl/svc_arb_pkg.sv
package svc_arb_pkg;

    // Fixed system slots ahead of the DMA group
    localparam int SLOT_RESET  = 0;
    localparam int SLOT_BUSERR = 1;
    localparam int SLOT_CMD    = 2;
    localparam int SYS_SLOTS   = 3;

    typedef enum logic [2:0] {
        TIER_NONE,
        TIER_RESET,
        TIER_BUSERR,
        TIER_CMD,
        TIER_DMA,
        TIER_URGENT,
        TIER_NORMAL
    } tier_e;

endpackage

// File: rtl/svc_arb_order.sv
// Flattens the grouped channel requests into one vector in service order.
// The lowest position in that vector has the highest rank.
module svc_arb_order #(
    parameter int N_FAST  = 3,
    parameter int N_MULTI = 2,
    parameter int N_SER   = 4,
    parameter int N_DBUF  = 4,
    localparam int N_CH   = 2*N_FAST + 2*N_MULTI + 2*N_SER + N_DBUF
) (
    input  logic [N_FAST-1:0]  fast_rx_req,
    input  logic [N_FAST-1:0]  fast_tx_req,
    input  logic [N_FAST-1:0]  fast_rx_urg,
    input  logic [N_FAST-1:0]  fast_tx_urg,
    input  logic [N_MULTI-1:0] multi_rx_req,
    input  logic [N_MULTI-1:0] multi_tx_req,
    input  logic [N_MULTI-1:0] multi_rx_urg,
    input  logic [N_MULTI-1:0] multi_tx_urg,
    input  logic [N_SER-1:0]   ser_rx_req,
    input  logic [N_SER-1:0]   ser_tx_req,
    input  logic [N_SER-1:0]   ser_rx_urg,
    input  logic [N_SER-1:0]   ser_tx_urg,
    input  logic [N_DBUF-1:0]  dbuf_req,
    output logic [N_CH-1:0]    ch_req,
    output logic [N_CH-1:0]    ch_urg
);
    localparam int MRX_BASE  = 2;
    localparam int MTX_BASE  = MRX_BASE + N_MULTI;
    localparam int FREST     = MTX_BASE + N_MULTI;
    localparam int SER_BASE  = 2*N_FAST + 2*N_MULTI;
    localparam int DBUF_BASE = SER_BASE + 2*N_SER;

    // Fast channel 0 leads the channel order
    assign ch_req[0] = fast_rx_req[0];
    assign ch_req[1] = fast_tx_req[0];
    assign ch_urg[0] = fast_rx_req[0] & fast_rx_urg[0];
    assign ch_urg[1] = fast_tx_req[0] & fast_tx_urg[0];

    // Multichannel block: all receives, then all transmits
    for (genvar m = 0; m < N_MULTI; m++) begin : g_multi
        assign ch_req[MRX_BASE+m] = multi_rx_req[m];
        assign ch_req[MTX_BASE+m] = multi_tx_req[m];
        assign ch_urg[MRX_BASE+m] = multi_rx_req[m] & multi_rx_urg[m];
        assign ch_urg[MTX_BASE+m] = multi_tx_req[m] & multi_tx_urg[m];
    end

    // Remaining fast channels in rx/tx pairs
    for (genvar f = 1; f < N_FAST; f++) begin : g_fast
        assign ch_req[FREST+2*(f-1)]   = fast_rx_req[f];
        assign ch_req[FREST+2*(f-1)+1] = fast_tx_req[f];
        assign ch_urg[FREST+2*(f-1)]   = fast_rx_req[f] & fast_rx_urg[f];
        assign ch_urg[FREST+2*(f-1)+1] = fast_tx_req[f] & fast_tx_urg[f];
    end

    for (genvar s = 0; s < N_SER; s++) begin : g_ser
        assign ch_req[SER_BASE+2*s]   = ser_rx_req[s];
        assign ch_req[SER_BASE+2*s+1] = ser_tx_req[s];
        assign ch_urg[SER_BASE+2*s]   = ser_rx_req[s] & ser_rx_urg[s];
        assign ch_urg[SER_BASE+2*s+1] = ser_tx_req[s] & ser_tx_urg[s];
    end

    // Double-buffered controllers cannot be urgent
    for (genvar d = 0; d < N_DBUF; d++) begin : g_dbuf
        assign ch_req[DBUF_BASE+d] = dbuf_req[d];
        assign ch_urg[DBUF_BASE+d] = 1'b0;
    end

endmodule

// File: rtl/svc_arb_pick.sv
// Finds the lowest set bit of a request vector.
module svc_arb_pick #(
    parameter int W   = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = W-1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

    // R8: the reported position is a live request and nothing below it is set
    always_comb begin
        if (hit) begin
            p_pick_live_r8: assert (vec[idx]);
            p_pick_lowest_r8: assert ((vec & ((W'(1) << idx) - W'(1))) == '0);
        end else begin
            p_pick_empty_r10: assert (vec == '0);
        end
    end

endmodule

// File: rtl/svc_req_arbiter.sv
module svc_req_arbiter
    import svc_arb_pkg::*;
#(
    parameter int N_DMA   = 4,
    parameter int N_FAST  = 3,
    parameter int N_MULTI = 2,
    parameter int N_SER   = 4,
    parameter int N_DBUF  = 4,
    localparam int N_CH   = 2*N_FAST + 2*N_MULTI + 2*N_SER + N_DBUF,
    localparam int DMA_BASE = SYS_SLOTS,
    localparam int CH_BASE  = SYS_SLOTS + N_DMA,
    localparam int TOTAL    = CH_BASE + N_CH,
    localparam int IW       = $clog2(TOTAL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reset_req,
    input  logic               bus_err_req,
    input  logic               host_cmd_req,
    input  logic [N_DMA-1:0]   dma_req,
    input  logic               dma_low_opt,
    input  logic [N_FAST-1:0]  fast_rx_req,
    input  logic [N_FAST-1:0]  fast_tx_req,
    input  logic [N_FAST-1:0]  fast_rx_urg,
    input  logic [N_FAST-1:0]  fast_tx_urg,
    input  logic [N_MULTI-1:0] multi_rx_req,
    input  logic [N_MULTI-1:0] multi_tx_req,
    input  logic [N_MULTI-1:0] multi_rx_urg,
    input  logic [N_MULTI-1:0] multi_tx_urg,
    input  logic [N_SER-1:0]   ser_rx_req,
    input  logic [N_SER-1:0]   ser_tx_req,
    input  logic [N_SER-1:0]   ser_rx_urg,
    input  logic [N_SER-1:0]   ser_tx_urg,
    input  logic [N_DBUF-1:0]  dbuf_req,
    input  logic               accept,
    output logic [TOTAL-1:0]   grant,
    output logic [IW-1:0]      grant_idx,
    output logic               grant_valid
);
    localparam int DW = (N_DMA > 1) ? $clog2(N_DMA) : 1;
    localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1;

    typedef struct packed {
        logic             valid;
        tier_e            tier;
        logic [IW-1:0]    idx;
        logic [TOTAL-1:0] onehot;
    } arb_state_t;

    arb_state_t state_d, state_q;

    logic [N_CH-1:0] ch_req, ch_urg;
    logic            dma_hit, urg_hit, norm_hit;
    logic [DW-1:0]   dma_idx;
    logic [CW-1:0]   urg_idx, norm_idx;
    logic            decide;
    tier_e           win_tier;
    logic [IW-1:0]   win_idx;

    svc_arb_order #(
        .N_FAST (N_FAST),
        .N_MULTI(N_MULTI),
        .N_SER  (N_SER),
        .N_DBUF (N_DBUF)
    ) u_order (
        .fast_rx_req (fast_rx_req),
        .fast_tx_req (fast_tx_req),
        .fast_rx_urg (fast_rx_urg),
        .fast_tx_urg (fast_tx_urg),
        .multi_rx_req(multi_rx_req),
        .multi_tx_req(multi_tx_req),
        .multi_rx_urg(multi_rx_urg),
        .multi_tx_urg(multi_tx_urg),
        .ser_rx_req  (ser_rx_req),
        .ser_tx_req  (ser_tx_req),
        .ser_rx_urg  (ser_rx_urg),
        .ser_tx_urg  (ser_tx_urg),
        .dbuf_req    (dbuf_req),
        .ch_req      (ch_req),
        .ch_urg      (ch_urg)
    );

    svc_arb_pick #(.W(N_DMA)) u_pick_dma (.vec(dma_req), .hit(dma_hit),  .idx(dma_idx));
    svc_arb_pick #(.W(N_CH))  u_pick_urg (.vec(ch_urg),  .hit(urg_hit),  .idx(urg_idx));
    svc_arb_pick #(.W(N_CH))  u_pick_ch  (.vec(ch_req),  .hit(norm_hit), .idx(norm_idx));

    always_comb begin
        decide = !state_q.valid || accept;
        win_tier = TIER_NONE;
        win_idx  = '0;
        if (reset_req) begin
            win_tier = TIER_RESET;
            win_idx  = IW'(SLOT_RESET);
        end else if (bus_err_req) begin
            win_tier = TIER_BUSERR;
            win_idx  = IW'(SLOT_BUSERR);
        end else if (host_cmd_req) begin
            win_tier = TIER_CMD;
            win_idx  = IW'(SLOT_CMD);
        end else if (dma_hit && !dma_low_opt) begin
            win_tier = TIER_DMA;
            win_idx  = IW'(DMA_BASE) + IW'(dma_idx);
        end else if (urg_hit) begin
            win_tier = TIER_URGENT;
            win_idx  = IW'(CH_BASE) + IW'(urg_idx);
        end else if (dma_hit) begin
            win_tier = TIER_DMA;
            win_idx  = IW'(DMA_BASE) + IW'(dma_idx);
        end else if (norm_hit) begin
            win_tier = TIER_NORMAL;
            win_idx  = IW'(CH_BASE) + IW'(norm_idx);
        end

        state_d = state_q;
        if (decide) begin
            state_d.valid  = (win_tier != TIER_NONE);
            state_d.tier   = win_tier;
            state_d.idx    = win_idx;
            state_d.onehot = (win_tier != TIER_NONE) ? (TOTAL'(1) << win_idx) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{valid: 1'b0, tier: TIER_NONE, idx: '0, onehot: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign grant       = state_q.onehot;
    assign grant_idx   = state_q.idx;
    assign grant_valid = state_q.valid;

    // R9: an outstanding grant is frozen until accepted
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !accept) |=> (grant_valid && $stable(grant_idx) && $stable(grant)));

    // R2: reset request wins at any decision edge
    p_reset_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((!grant_valid || accept) && reset_req) |=> (grant_valid && grant_idx == IW'(SLOT_RESET)));

    // R3: bus error second
    p_buserr_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((!grant_valid || accept) && !reset_req && bus_err_req)
        |=> (grant_valid && grant_idx == IW'(SLOT_BUSERR)));

    // R4: host command third
    p_cmd_third_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((!grant_valid || accept) && !reset_req && !bus_err_req && host_cmd_req)
        |=> (grant_valid && grant_idx == IW'(SLOT_CMD)));

    // R6: in the low DMA mode an urgent channel takes a channel slot, not a DMA slot
    p_urgent_over_dma_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!grant_valid || accept) && !reset_req && !bus_err_req && !host_cmd_req
         && dma_low_opt && urg_hit) |=> (grant_valid && grant_idx >= IW'(CH_BASE)));

    // R10: grant shape follows the index and valid flag
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant == (TOTAL'(1) << grant_idx)));
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (grant == '0));

endmodule

// File: tb/svc_req_arbiter_test.sv
module svc_req_arbiter_test;

    localparam int TOT = 29;

    typedef struct packed {
        logic           opt;
        logic [TOT-1:0] req;
        logic [TOT-1:0] urg;
        logic           ev;
        logic [4:0]     ei;
        logic [3:0]     tag;
    } vec_t;

    function automatic logic [TOT-1:0] b(input int i);
        return TOT'(1) << i;
    endfunction

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, b(0)|b(1)|b(2)|b(3),  '0,          1'b1, 5'd0,  4'd2},  // R2
        '{1'b0, b(1)|b(2)|b(7),       b(7),        1'b1, 5'd1,  4'd3},  // R3
        '{1'b0, b(2)|b(6)|b(7),       b(7),        1'b1, 5'd2,  4'd4},  // R4
        '{1'b0, b(5)|b(4)|b(7),       b(7),        1'b1, 5'd4,  4'd5},  // R5
        '{1'b0, b(6)|b(12),           b(12),       1'b1, 5'd6,  4'd5},  // R5
        '{1'b1, b(4)|b(12),           b(12),       1'b1, 5'd12, 4'd6},  // R6
        '{1'b1, b(6)|b(7),            '0,          1'b1, 5'd6,  4'd6},  // R6
        '{1'b0, b(8)|b(12),           b(8)|b(12),  1'b1, 5'd8,  4'd7},  // R7
        '{1'b0, b(7)|b(12),           b(12),       1'b1, 5'd12, 4'd7},  // R7
        '{1'b0, b(9),                 b(7),        1'b1, 5'd9,  4'd7},  // R7
        '{1'b1, b(3)|b(9),            b(7),        1'b1, 5'd3,  4'd7},  // R7
        '{1'b0, b(11)|b(10),          '0,          1'b1, 5'd10, 4'd8},  // R8
        '{1'b0, b(15)|b(14)|b(17),    '0,          1'b1, 5'd14, 4'd8},  // R8
        '{1'b0, b(28)|b(24)|b(18),    '0,          1'b1, 5'd18, 4'd8},  // R8
        '{1'b0, '0,                   '1,          1'b0, 5'd0,  4'd10}  // R10
    };

    logic clk = 1'b0;
    logic rst_n;
    logic accept;
    logic opt;
    logic [TOT-1:0] req_all;
    logic [TOT-1:0] urg_all;
    logic [TOT-1:0] grant;
    logic [4:0] grant_idx;
    logic grant_valid;
    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    logic [3:0] dma_req, dbuf_req, ser_rx_req, ser_tx_req, ser_rx_urg, ser_tx_urg;
    logic [2:0] fast_rx_req, fast_tx_req, fast_rx_urg, fast_tx_urg;
    logic [1:0] multi_rx_req, multi_tx_req, multi_rx_urg, multi_tx_urg;

    // Port wiring taken from the R8 index list
    assign dma_req = req_all[6:3];
    assign fast_rx_req  = {req_all[15], req_all[13], req_all[7]};
    assign fast_tx_req  = {req_all[16], req_all[14], req_all[8]};
    assign fast_rx_urg  = {urg_all[15], urg_all[13], urg_all[7]};
    assign fast_tx_urg  = {urg_all[16], urg_all[14], urg_all[8]};
    assign multi_rx_req = req_all[10:9];
    assign multi_tx_req = req_all[12:11];
    assign multi_rx_urg = urg_all[10:9];
    assign multi_tx_urg = urg_all[12:11];
    assign ser_rx_req = {req_all[23], req_all[21], req_all[19], req_all[17]};
    assign ser_tx_req = {req_all[24], req_all[22], req_all[20], req_all[18]};
    assign ser_rx_urg = {urg_all[23], urg_all[21], urg_all[19], urg_all[17]};
    assign ser_tx_urg = {urg_all[24], urg_all[22], urg_all[20], urg_all[18]};
    assign dbuf_req = req_all[28:25];

    svc_req_arbiter uut (
        .clk(clk), .rst_n(rst_n),
        .reset_req(req_all[0]), .bus_err_req(req_all[1]), .host_cmd_req(req_all[2]),
        .dma_req(dma_req), .dma_low_opt(opt),
        .fast_rx_req(fast_rx_req), .fast_tx_req(fast_tx_req),
        .fast_rx_urg(fast_rx_urg), .fast_tx_urg(fast_tx_urg),
        .multi_rx_req(multi_rx_req), .multi_tx_req(multi_tx_req),
        .multi_rx_urg(multi_rx_urg), .multi_tx_urg(multi_tx_urg),
        .ser_rx_req(ser_rx_req), .ser_tx_req(ser_tx_req),
        .ser_rx_urg(ser_rx_urg), .ser_tx_urg(ser_tx_urg),
        .dbuf_req(dbuf_req), .accept(accept),
        .grant(grant), .grant_idx(grant_idx), .grant_valid(grant_valid)
    );

    task automatic expect_grant(input logic ev, input logic [4:0] ei, input int tag);
        logic [TOT-1:0] eg;
        logic [4:0] eidx;
        eg   = ev ? (TOT'(1) << ei) : '0;
        eidx = ev ? ei : 5'd0;
        checks++;
        if (grant_valid !== ev || grant !== eg || grant_idx !== eidx) begin
            fails++;
            $display("FAIL R%0d: valid=%0b idx=%0d grant=%h, expected valid=%0b idx=%0d grant=%h",
                     tag, grant_valid, grant_idx, grant, ev, eidx, eg);
        end
    endtask

    initial begin
        rst_n = 1'b0; accept = 1'b0; opt = 1'b0; req_all = '0; urg_all = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        expect_grant(1'b0, 5'd0, 1);   // R1 reset state
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            opt = VECS[k].opt; req_all = VECS[k].req; urg_all = VECS[k].urg; accept = 1'b1;
            @(negedge clk);
            expect_grant(VECS[k].ev, VECS[k].ei, int'(VECS[k].tag));
        end

        // R9: grant held while the mode and requests change
        accept = 1'b0; opt = 1'b0; req_all = b(13); urg_all = '0;
        @(negedge clk);
        expect_grant(1'b1, 5'd13, 9);
        opt = 1'b1; req_all = b(3) | b(7); urg_all = b(7);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            expect_grant(1'b1, 5'd13, 9);   // R9 hold
        end
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
        expect_grant(1'b1, 5'd7, 6);       // R6 new mode at the next decision
        req_all = b(0) | b(7);
        @(negedge clk);
        expect_grant(1'b1, 5'd7, 9);       // R9 reset request waits for accept
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
        expect_grant(1'b1, 5'd0, 2);       // R2

        // R10: decision with nothing pending, then idle re-decides without accept
        req_all = '0; urg_all = '0; accept = 1'b1;
        @(negedge clk);
        expect_grant(1'b0, 5'd0, 10);
        accept = 1'b0; req_all = b(20);
        @(negedge clk);
        expect_grant(1'b1, 5'd20, 10);     // R10 idle picks up without accept

        // R1: asynchronous reset in the middle of a held grant
        #2 rst_n = 1'b0;
        #1 expect_grant(1'b0, 5'd0, 1);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule